// File: doc/BRIEF.md
# Debugger-to-core word mailbox

This block passes 32-bit words in both directions between an external debug probe and the processor it controls. The probe side sees a small register file through a single-cycle access strobe carrying an address, a direction bit and write data. Two addresses are decoded: a data address that moves words, and a control address that reports the handshake state. The core side has a pop strobe and the word waiting for it, a push strobe with the word it offers, and a status vector.

Each direction has a one-word holding register with a full flag and a sticky overrun flag. A probe read of the data address hands over the word the core offered and consumes it. A probe read of the control address only observes. The top four bits of the control value carry a fixed version code. Both sides run on one clock; serial shifting and clock crossing sit outside the block.

Top module: `dbgchan_mbox`

## Requirements
- R1: After reset both words read as zero, both full flags and both overrun flags are 0. A reset in the middle of traffic returns the block to this state.
- R2: A probe read of the control address (4) returns the version parameter (default 6) in bits 31:28. Bit 0 is the to-core full flag, bit 1 the to-probe full flag, bit 2 the to-core overrun flag, bit 3 the to-probe overrun flag. All other bits read 0. The core status port carries the same four flags in bits 3:0.
- R3: A probe write (direction bit 1) to the data address (5) stores the word for the core and sets the to-core full flag from the next cycle on. `core_rdata` shows the word from that cycle.
- R4: A core pop clears the to-core full flag in the next cycle.
- R5: A core push stores its word and sets the to-probe full flag in the next cycle. A probe read of the data address returns that word in the same cycle as the strobe and clears the to-probe full flag in the next cycle.
- R6: A probe read of the control address leaves every flag and both words unchanged.
- R7: A push into a direction whose full flag is set, with no pop of that direction in the same cycle, replaces the held word and sets that direction's overrun flag.
- R8: When a push and a pop of the same direction fall in one cycle, the full flag stays set and the new word is held. No overrun is raised.
- R9: Overrun flags stay set until reset.
- R10: Probe writes to the control address, and probe accesses to any address other than 4 or 5, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_req | input | 1 | Probe access strobe, one cycle per access |
| dbg_wr | input | 1 | Probe direction: 1 write, 0 read |
| dbg_addr | input | 5 | Probe register address |
| dbg_wdata | input | 32 | Probe write data |
| dbg_rdata | output | 32 | Probe read data for the current address |
| core_rd | input | 1 | Core pops the word sent by the probe |
| core_rdata | output | 32 | Word held for the core |
| core_wr | input | 1 | Core pushes a word for the probe |
| core_wdata | input | 32 | Word pushed by the core |
| core_status | output | 4 | Overrun to probe, overrun to core, to-probe full, to-core full (bit 3 down to 0) |

## Verification
Read data is combinational, so the bench samples `dbg_rdata` a short delay after it drives the strobe, in the same cycle. Flags and held words change on the first clock edge after a strobe. The bench drives every strobe on a falling edge and samples flags and words on the next falling edge, once that single edge has passed. Same-cycle push and pop are applied in one falling-edge slot, which exercises the set-over-clear priority exactly.

// File: rtl/dbgchan_pkg.sv
package dbgchan_pkg;
   // status bit positions shared by control read value and core status port
   localparam int ST_TOCORE_FULL = 0;
   localparam int ST_TOPROBE_FULL = 1;
   localparam int ST_TOCORE_OVR = 2;
   localparam int ST_TOPROBE_OVR = 3;
   localparam int ST_W = 4;
   localparam int CTRL_IMPL_W = 6;

   typedef struct packed {
      logic toprobe_ovr;
      logic tocore_ovr;
      logic toprobe_full;
      logic tocore_full;
   } mbox_status_t;
endpackage

// File: rtl/dbgchan_slot.sv
module dbgchan_slot #(
   parameter int DATA_W = 32,
   parameter bit CLEAR_WORD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] word,
   output logic              full,
   output logic              ovr
);
   logic full_nx;
   logic ovr_nx;

   // a set wins over a clear landing in the same cycle
   always_comb begin
      full_nx = full;
      if (pop) full_nx = 1'b0;
      if (push) full_nx = 1'b1;
      ovr_nx = ovr | (push & full & ~pop);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full <= 1'b0;
         ovr  <= 1'b0;
      end else begin
         full <= full_nx;
         ovr  <= ovr_nx;
      end
   end

   generate
      if (CLEAR_WORD) begin : g_word_rst
         always_ff @(posedge clk) begin
            if (!rst_n) word <= '0;
            else if (push) word <= push_data;
         end
      end else begin : g_word_norst
         always_ff @(posedge clk) begin
            if (push) word <= push_data;
         end
      end
   endgenerate
endmodule

// File: rtl/dbgchan_decode.sv
module dbgchan_decode #(
   parameter int ADDR_W = 5,
   parameter int CTRL_ADDR = 4,
   parameter int DATA_ADDR = 5
) (
   input  logic              dbg_req,
   input  logic              dbg_wr,
   input  logic [ADDR_W-1:0] dbg_addr,
   output logic              sel_ctrl,
   output logic              sel_data,
   output logic              probe_push,
   output logic              probe_pop
);
   always_comb begin
      sel_ctrl   = (dbg_addr == ADDR_W'(CTRL_ADDR));
      sel_data   = (dbg_addr == ADDR_W'(DATA_ADDR));
      probe_push = dbg_req & dbg_wr & sel_data;
      probe_pop  = dbg_req & ~dbg_wr & sel_data;
   end
endmodule

// File: rtl/dbgchan_mbox.sv
module dbgchan_mbox #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 5,
   parameter int VER_W = 4,
   parameter int VERSION = 6,
   parameter int CTRL_ADDR = 4,
   parameter int DATA_ADDR = 5,
   parameter bit CLEAR_WORDS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg_req,
   input  logic              dbg_wr,
   input  logic [ADDR_W-1:0] dbg_addr,
   input  logic [DATA_W-1:0] dbg_wdata,
   output logic [DATA_W-1:0] dbg_rdata,
   input  logic              core_rd,
   output logic [DATA_W-1:0] core_rdata,
   input  logic              core_wr,
   input  logic [DATA_W-1:0] core_wdata,
   output logic [3:0]        core_status
);
   import dbgchan_pkg::*;

   localparam int PAD_W = DATA_W - VER_W - ST_W;

   generate
      if (DATA_W < VER_W + CTRL_IMPL_W) begin : g_bad_width
         $error("dbgchan_mbox: DATA_W too narrow for control layout");
      end
      if (VERSION < 0 || VERSION >= (1 << VER_W)) begin : g_bad_ver
         $error("dbgchan_mbox: VERSION does not fit VER_W");
      end
      if (CTRL_ADDR == DATA_ADDR || CTRL_ADDR >= (1 << ADDR_W) || DATA_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("dbgchan_mbox: register addresses clash or do not fit");
      end
   endgenerate

   logic sel_ctrl, sel_data, probe_push, probe_pop;
   logic [DATA_W-1:0] toprobe_word;
   mbox_status_t st;

   dbgchan_decode #(
      .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
   ) u_dec (
      .dbg_req(dbg_req), .dbg_wr(dbg_wr), .dbg_addr(dbg_addr),
      .sel_ctrl(sel_ctrl), .sel_data(sel_data),
      .probe_push(probe_push), .probe_pop(probe_pop)
   );

   // probe -> core direction
   dbgchan_slot #(.DATA_W(DATA_W), .CLEAR_WORD(CLEAR_WORDS)) u_tocore (
      .clk(clk), .rst_n(rst_n),
      .push(probe_push), .push_data(dbg_wdata), .pop(core_rd),
      .word(core_rdata), .full(st.tocore_full), .ovr(st.tocore_ovr)
   );

   // core -> probe direction
   dbgchan_slot #(.DATA_W(DATA_W), .CLEAR_WORD(CLEAR_WORDS)) u_toprobe (
      .clk(clk), .rst_n(rst_n),
      .push(core_wr), .push_data(core_wdata), .pop(probe_pop),
      .word(toprobe_word), .full(st.toprobe_full), .ovr(st.toprobe_ovr)
   );

   always_comb begin
      dbg_rdata = '0;
      if (sel_ctrl) dbg_rdata = {VER_W'(VERSION), PAD_W'(0), st};
      else if (sel_data) dbg_rdata = toprobe_word;
   end

   assign core_status = st;
endmodule

// File: rtl/dbgchan_mbox_chk.sv
module dbgchan_mbox_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 5,
   parameter int VER_W = 4,
   parameter int VERSION = 6,
   parameter int CTRL_ADDR = 4,
   parameter int DATA_ADDR = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dbg_req,
   input logic              dbg_wr,
   input logic [ADDR_W-1:0] dbg_addr,
   input logic [DATA_W-1:0] dbg_wdata,
   input logic [DATA_W-1:0] dbg_rdata,
   input logic              core_rd,
   input logic [DATA_W-1:0] core_rdata,
   input logic              core_wr,
   input logic [3:0]        core_status
);
   logic c_push, c_pop, c_ctrl_rd, c_ctrl_wr;
   assign c_push    = dbg_req && dbg_wr && dbg_addr == ADDR_W'(DATA_ADDR);
   assign c_pop     = dbg_req && !dbg_wr && dbg_addr == ADDR_W'(DATA_ADDR);
   assign c_ctrl_rd = dbg_req && !dbg_wr && dbg_addr == ADDR_W'(CTRL_ADDR);
   assign c_ctrl_wr = dbg_req && dbg_wr && dbg_addr == ADDR_W'(CTRL_ADDR);

   p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> core_status == 4'b0);
   p_version_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_addr == ADDR_W'(CTRL_ADDR) |-> dbg_rdata[DATA_W-1 -: VER_W] == VER_W'(VERSION));
   p_ctrl_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_addr == ADDR_W'(CTRL_ADDR) |-> dbg_rdata[3:0] == core_status);
   p_push_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      c_push |=> core_status[0] && core_rdata == $past(dbg_wdata));
   p_pop_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      core_rd && !c_push |=> !core_status[0]);
   p_probe_pop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      c_pop && !core_wr |=> !core_status[1]);
   p_ctrl_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      c_ctrl_rd && !core_rd && !core_wr |=> $stable(core_status) && $stable(core_rdata));
   p_core_push_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      core_wr |=> core_status[1]);
   p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      core_status[3:2] == 2'b11 |=> core_status[3:2] == 2'b11);
   p_ctrl_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      c_ctrl_wr && !core_rd && !core_wr |=> $stable(core_status) && $stable(core_rdata));
endmodule

bind dbgchan_mbox dbgchan_mbox_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VER_W(VER_W), .VERSION(VERSION),
   .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .dbg_req(dbg_req), .dbg_wr(dbg_wr),
   .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
   .core_rd(core_rd), .core_rdata(core_rdata), .core_wr(core_wr),
   .core_status(core_status)
);

// File: tb/dbgchan_mbox_tb.sv
module dbgchan_mbox_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        dbg_req, dbg_wr;
   logic [4:0]  dbg_addr;
   logic [31:0] dbg_wdata, dbg_rdata;
   logic        core_rd, core_wr;
   logic [31:0] core_rdata, core_wdata;
   logic [3:0]  core_status;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   dbgchan_mbox dut_i (
      .clk(clk), .rst_n(rst_n), .dbg_req(dbg_req), .dbg_wr(dbg_wr),
      .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
      .core_rd(core_rd), .core_rdata(core_rdata), .core_wr(core_wr),
      .core_wdata(core_wdata), .core_status(core_status)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic idle();
      dbg_req = 0; dbg_wr = 0; dbg_addr = '0; dbg_wdata = '0;
      core_rd = 0; core_wr = 0; core_wdata = '0;
   endtask

   // probe access: drive on falling edge, capture read data in-cycle
   task automatic probe(input logic wr, input logic [4:0] a, input logic [31:0] d,
                        output logic [31:0] rd);
      @(negedge clk);
      dbg_req = 1; dbg_wr = wr; dbg_addr = a; dbg_wdata = d;
      #1 rd = dbg_rdata;
      @(negedge clk);
      idle();
   endtask

   task automatic core_push(input logic [31:0] d);
      @(negedge clk); core_wr = 1; core_wdata = d;
      @(negedge clk); idle();
   endtask

   task automatic core_pop();
      @(negedge clk); core_rd = 1;
      @(negedge clk); idle();
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0;
      @(negedge clk); @(negedge clk); rst_n = 1;
   endtask

   task automatic t_reset_r1();
      logic [31:0] r;
      chk("R1 status", {28'b0, core_status}, 32'h0);
      chk("R1 core word", core_rdata, 32'h0);
      probe(1'b0, 5'd4, 32'h0, r);
      chk("R1/R2 ctrl", r, 32'h6000_0000);
   endtask

   task automatic t_write_r3_r4();
      logic [31:0] r;
      probe(1'b1, 5'd5, 32'hA5A5_0001, r);
      chk("R3 full", {28'b0, core_status}, 32'h1);
      chk("R3 word", core_rdata, 32'hA5A5_0001);
      core_pop();
      chk("R4 cleared", {28'b0, core_status}, 32'h0);
   endtask

   task automatic t_core_send_r5_r6();
      logic [31:0] r;
      core_push(32'h1234_5678);
      chk("R5 full", {28'b0, core_status}, 32'h2);
      probe(1'b0, 5'd4, 32'h0, r);
      chk("R2 ctrl flags", r, 32'h6000_0002);
      probe(1'b0, 5'd4, 32'h0, r);
      chk("R6 ctrl read no change", {28'b0, core_status}, 32'h2);
      probe(1'b0, 5'd5, 32'h0, r);
      chk("R5 read word", r, 32'h1234_5678);
      chk("R5 cleared", {28'b0, core_status}, 32'h0);
   endtask

   task automatic t_same_cycle_r8();
      logic [31:0] r;
      probe(1'b1, 5'd5, 32'h0000_0111, r);
      @(negedge clk);
      dbg_req = 1; dbg_wr = 1; dbg_addr = 5'd5; dbg_wdata = 32'h0000_0222; core_rd = 1;
      @(negedge clk); idle();
      chk("R8 to-core set wins", {28'b0, core_status}, 32'h1);
      chk("R8 to-core word", core_rdata, 32'h0000_0222);
      core_pop();
      core_push(32'hCAFE_0001);
      @(negedge clk);
      dbg_req = 1; dbg_wr = 0; dbg_addr = 5'd5; core_wr = 1; core_wdata = 32'hCAFE_0002;
      #1 r = dbg_rdata;
      @(negedge clk); idle();
      chk("R8 read old word", r, 32'hCAFE_0001);
      chk("R8 to-probe set wins", {28'b0, core_status}, 32'h2);
      probe(1'b0, 5'd5, 32'h0, r);
      chk("R8 new word", r, 32'hCAFE_0002);
   endtask

   task automatic t_overrun_r7_r9();
      logic [31:0] r;
      probe(1'b1, 5'd5, 32'h0000_AAAA, r);
      probe(1'b1, 5'd5, 32'h0000_BBBB, r);
      chk("R7 to-core overwrite", core_rdata, 32'h0000_BBBB);
      chk("R7 to-core ovr", {28'b0, core_status}, 32'h5);
      core_push(32'h0000_CCCC);
      core_push(32'h0000_DDDD);
      chk("R7 to-probe ovr", {28'b0, core_status}, 32'hF);
      probe(1'b0, 5'd5, 32'h0, r);
      chk("R7 to-probe overwrite", r, 32'h0000_DDDD);
      core_pop();
      chk("R9 sticky", {28'b0, core_status}, 32'hC);
      probe(1'b0, 5'd4, 32'h0, r);
      chk("R9/R2 ctrl", r, 32'h6000_000C);
   endtask

   task automatic t_ignored_r10();
      logic [31:0] r;
      probe(1'b1, 5'd4, 32'hFFFF_FFFF, r);
      chk("R10 ctrl write status", {28'b0, core_status}, 32'hC);
      chk("R10 ctrl write word", core_rdata, 32'h0000_BBBB);
      probe(1'b1, 5'd7, 32'h1357_9BDF, r);
      chk("R10 other addr word", core_rdata, 32'h0000_BBBB);
      chk("R10 other addr status", {28'b0, core_status}, 32'hC);
      probe(1'b0, 5'd7, 32'h0, r);
      chk("R10 other addr read", r, 32'h0);
   endtask

   task automatic t_midreset_r1();
      logic [31:0] r;
      probe(1'b1, 5'd5, 32'h0BAD_F00D, r);
      core_push(32'h0BAD_BEEF);
      do_reset();
      chk("R1 reset status", {28'b0, core_status}, 32'h0);
      chk("R1 reset word", core_rdata, 32'h0);
      probe(1'b0, 5'd5, 32'h0, r);
      chk("R1 reset probe word", r, 32'h0);
   endtask

   initial begin
      idle();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset_r1();
      t_write_r3_r4();
      t_core_send_r5_r6();
      t_same_cycle_r8();
      t_overrun_r7_r9();
      t_ignored_r10();
      t_midreset_r1();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule